// File: doc/BRIEF.md
# Pixel Hit Arrival-Time and Time-over-Threshold Capture

This block sits in the digital part of one pixel. From a single discriminator pulse it measures two things: when the pulse began and how long it stayed above threshold. The arrival time is built from two parts. The coarse part is the global time-stamp bus, which advances once per reference-clock period. The fine part is an interpolating count taken in a fast-clock domain. That domain runs at sixteen times the reference frequency and is phase-locked to it. The time over threshold is counted in reference-clock periods during the same hit.

Both results are packed into one fixed-format word. The word is presented with a valid flag and held until the readout logic acknowledges it. While a word is waiting, new pulses are discarded. Capture is re-armed one reference cycle after the acknowledge.

Top module: `pix_hit_capture`

## Requirements
- R1: After reset, `dataValid` is 0 and `dataWord` is all zeros.
- R2: The word layout is bits 17:8 for the coarse stamp, bits 7:4 for the ToT count and bits 3:0 for the fine count. `dataValid` rises no later than six reference periods after the discriminator returns low.
- R3: The coarse stamp equals the value of `coarseTime` sampled at the first reference rising edge after the discriminator rises. The stamp wraps with the bus.
- R4: The fine count equals the number of whole fast-clock periods from the discriminator's rising edge to the next reference rising edge (1 to 15 with the 16:1 locked clocks). It saturates at 15.
- R5: The ToT count equals the number of reference rising edges at which the discriminator is high. It saturates at 15.
- R6: A pulse that spans no reference rising edge is recorded with a ToT count of 1.
- R7: While `dataValid` is high and `readAck` is low, `dataWord` and `dataValid` stay unchanged.
- R8: When `readAck` is high on an edge with `dataValid` high, `dataValid` is 0 in the following cycle and in the one after it.
- R9: A pulse that arrives while a word is pending leaves the stored word unchanged. It produces no word after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock (40 MHz class); all outputs are in this domain |
| fastClk | input | 1 | Fast interpolation clock, 16x refClk, phase-locked |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| discIn | input | 1 | Asynchronous discriminator output |
| coarseTime | input | 10 | Global coarse time-stamp bus, advancing once per reference period |
| readAck | input | 1 | Readout acknowledge for the pending word |
| dataValid | output | 1 | A complete word is pending |
| dataWord | output | 18 | Packed stamp, ToT and fine count |

## Verification
The hardest situation to reach is a second pulse arriving while a word is still pending. It must not disturb the stored word. Its own counting must not leak into the next accepted hit after the re-arm. The stimulus reaches this by withholding the acknowledge, firing a multi-period pulse, and only then acknowledging. It then checks that no word follows, and that a fresh hit afterwards reports its own ToT. A second delicate point is the placement of the discriminator edge within the reference period. The stimulus sweeps that phase across the whole period so the fine count is checked at both ends of its range.

// File: rtl/pix_cap_pkg.sv
package pix_cap_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_MEAS  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_REARM = 2'd3
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armed;    // idle and no hit arriving: ToT counter may be cleared
    logic capture;  // latch stamp and fine count
    logic finish;   // latch ToT count
  } capStrobe_t;

endpackage

// File: rtl/pix_sync_chain.sv
module pix_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[STAGES-2:0], d};
  end

  assign q = shiftQ[STAGES-1];

endmodule

// File: rtl/pix_fine_interp.sv
module pix_fine_interp #(
  parameter int FINE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              fastClk,
  input  logic              rstN,
  input  logic              discIn,
  input  logic              refClk,
  output logic [FINE_W-1:0] fineHold,
  output logic              doneTog
);

  localparam logic [FINE_W-1:0] FINE_MAX = '1;

  logic discSync, discPrev, refSync, refPrev;
  logic discRise, refRise, running;
  logic [FINE_W-1:0] fineCnt;

  pix_sync_chain #(.STAGES(SYNC_STAGES)) uDiscSync (
    .clk(fastClk), .rstN(rstN), .d(discIn), .q(discSync)
  );

  // the reference clock is sampled as data; equal latency on both paths cancels
  pix_sync_chain #(.STAGES(SYNC_STAGES)) uRefSync (
    .clk(fastClk), .rstN(rstN), .d(refClk), .q(refSync)
  );

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      discPrev <= 1'b0;
      refPrev  <= 1'b0;
    end else begin
      discPrev <= discSync;
      refPrev  <= refSync;
    end
  end

  assign discRise = discSync & ~discPrev;
  assign refRise  = refSync & ~refPrev;

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      fineCnt  <= '0;
      fineHold <= '0;
      doneTog  <= 1'b0;
    end else if (discRise) begin
      running <= 1'b1;
      fineCnt <= {{(FINE_W-1){1'b0}}, 1'b1};
    end else if (running && refRise) begin
      running  <= 1'b0;
      fineHold <= fineCnt;
      doneTog  <= ~doneTog;
    end else if (running) begin
      fineCnt <= (fineCnt == FINE_MAX) ? FINE_MAX : fineCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pix_capture_dp.sv
module pix_capture_dp
  import pix_cap_pkg::*;
#(
  parameter int STAMP_W     = 10,
  parameter int TOT_W       = 4,
  parameter int FINE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              refClk,
  input  logic                              rstN,
  input  logic                              discIn,
  input  logic [STAMP_W-1:0]                coarseTime,
  input  logic [FINE_W-1:0]                 fineHold,
  input  logic                              doneTog,
  input  capStrobe_t                        strb,
  output logic                              hitDet,
  output logic                              discLow,
  output logic [STAMP_W+TOT_W+FINE_W-1:0]   dataWord
);

  // bus pipeline depth matches the fine-done handoff latency
  localparam int STAMP_DLY = SYNC_STAGES + 1;
  localparam logic [TOT_W-1:0] TOT_MAX = '1;
  localparam logic [TOT_W-1:0] TOT_ONE = {{(TOT_W-1){1'b0}}, 1'b1};

  logic discSync, discPrev, togSync, togPrev;
  logic [STAMP_W-1:0] stampPipe [STAMP_DLY];
  logic [FINE_W-1:0]  fineRef, fineReg;
  logic [TOT_W-1:0]   totCnt, totReg;
  logic [STAMP_W-1:0] stampReg;

  pix_sync_chain #(.STAGES(SYNC_STAGES)) uDiscSync (
    .clk(refClk), .rstN(rstN), .d(discIn), .q(discSync)
  );

  pix_sync_chain #(.STAGES(SYNC_STAGES)) uTogSync (
    .clk(refClk), .rstN(rstN), .d(doneTog), .q(togSync)
  );

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      discPrev <= 1'b0;
      togPrev  <= 1'b0;
      fineRef  <= '0;
    end else begin
      discPrev <= discSync;
      togPrev  <= togSync;
      fineRef  <= fineHold;
    end
  end

  assign hitDet  = togSync ^ togPrev;
  assign discLow = ~discSync;

  genvar g;
  generate
    for (g = 0; g < STAMP_DLY; g++) begin : gStamp
      always_ff @(posedge refClk or negedge rstN) begin
        if (!rstN)      stampPipe[g] <= '0;
        else if (g == 0) stampPipe[g] <= coarseTime;
        else            stampPipe[g] <= stampPipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      totCnt <= '0;
    end else if (discSync) begin
      totCnt <= !discPrev ? TOT_ONE :
                (totCnt == TOT_MAX) ? TOT_MAX : totCnt + 1'b1;
    end else if (strb.armed) begin
      totCnt <= '0;
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      stampReg <= '0;
      fineReg  <= '0;
      totReg   <= '0;
    end else begin
      if (strb.capture) begin
        stampReg <= stampPipe[STAMP_DLY-1];
        fineReg  <= fineRef;
      end
      if (strb.finish) begin
        totReg <= (totCnt == '0) ? TOT_ONE : totCnt;
      end
    end
  end

  assign dataWord = {stampReg, totReg, fineReg};

endmodule

// File: rtl/pix_capture_ctrl.sv
module pix_capture_ctrl
  import pix_cap_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic       hitDet,
  input  logic       discLow,
  input  logic       readAck,
  output capStrobe_t strb,
  output logic       dataValid
);

  capState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    strb.armed   = 1'b0;
    strb.capture = 1'b0;
    strb.finish  = 1'b0;
    case (state)
      ST_ARMED: begin
        if (hitDet) begin
          strb.capture = 1'b1;
          stateNext    = ST_MEAS;
        end else begin
          strb.armed = 1'b1;
        end
      end
      ST_MEAS: begin
        if (discLow) begin
          strb.finish = 1'b1;
          stateNext   = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (readAck) stateNext = ST_REARM;
      end
      default: stateNext = ST_ARMED;
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) state <= ST_ARMED;
    else       state <= stateNext;
  end

  assign dataValid = (state == ST_HOLD);

endmodule

// File: rtl/pix_hit_capture.sv
module pix_hit_capture
  import pix_cap_pkg::*;
#(
  parameter int STAMP_W     = 10,
  parameter int TOT_W       = 4,
  parameter int FINE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            refClk,
  input  logic                            fastClk,
  input  logic                            rstN,
  input  logic                            discIn,
  input  logic [STAMP_W-1:0]              coarseTime,
  input  logic                            readAck,
  output logic                            dataValid,
  output logic [STAMP_W+TOT_W+FINE_W-1:0] dataWord
);

  logic [FINE_W-1:0] fineHold;
  logic              doneTog, hitDet, discLow;
  capStrobe_t        strb;

  pix_fine_interp #(.FINE_W(FINE_W), .SYNC_STAGES(SYNC_STAGES)) uFine (
    .fastClk(fastClk), .rstN(rstN), .discIn(discIn), .refClk(refClk),
    .fineHold(fineHold), .doneTog(doneTog)
  );

  pix_capture_dp #(
    .STAMP_W(STAMP_W), .TOT_W(TOT_W), .FINE_W(FINE_W), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .refClk(refClk), .rstN(rstN), .discIn(discIn), .coarseTime(coarseTime),
    .fineHold(fineHold), .doneTog(doneTog), .strb(strb),
    .hitDet(hitDet), .discLow(discLow), .dataWord(dataWord)
  );

  pix_capture_ctrl uCtrl (
    .refClk(refClk), .rstN(rstN), .hitDet(hitDet), .discLow(discLow),
    .readAck(readAck), .strb(strb), .dataValid(dataValid)
  );

endmodule

// File: rtl/pix_hit_capture_checker.sv
module pix_hit_capture_checker #(
  parameter int STAMP_W = 10,
  parameter int TOT_W   = 4,
  parameter int FINE_W  = 4
) (
  input logic                            refClk,
  input logic                            rstN,
  input logic                            readAck,
  input logic                            dataValid,
  input logic [STAMP_W+TOT_W+FINE_W-1:0] dataWord
);

  logic [TOT_W-1:0]  totField;
  logic [FINE_W-1:0] fineField;
  assign totField  = dataWord[TOT_W+FINE_W-1:FINE_W];
  assign fineField = dataWord[FINE_W-1:0];

  a_r7_hold_stable: assert property (@(posedge refClk) disable iff (!rstN)
    (dataValid && !readAck) |=> (dataValid && $stable(dataWord)));

  a_r8_drop_after_ack: assert property (@(posedge refClk) disable iff (!rstN)
    (dataValid && readAck) |=> !dataValid ##1 !dataValid);

  a_r6_tot_nonzero: assert property (@(posedge refClk) disable iff (!rstN)
    dataValid |-> (totField != '0));

  a_r4_fine_nonzero: assert property (@(posedge refClk) disable iff (!rstN)
    dataValid |-> (fineField != '0));

  a_r2_word_settled: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(dataValid) |=> $stable(dataWord));

endmodule

bind pix_hit_capture pix_hit_capture_checker #(
  .STAMP_W(STAMP_W), .TOT_W(TOT_W), .FINE_W(FINE_W)
) uChk (
  .refClk(refClk), .rstN(rstN), .readAck(readAck),
  .dataValid(dataValid), .dataWord(dataWord)
);

// File: tb/pix_hit_capture_test.sv
`timescale 1ns/1ps
module pix_hit_capture_test;

  localparam int REF_PERIOD = 32;
  localparam int FAST_HALF  = 1;
  localparam int STAMP_W    = 10;
  localparam int TOT_W      = 4;
  localparam int FINE_W     = 4;
  localparam int WORD_W     = STAMP_W + TOT_W + FINE_W;
  localparam int NVEC       = 8;
  // discriminator phase after the reference edge, and pulse width in edges
  localparam int VEC_OFF [NVEC] = '{2, 6, 10, 14, 18, 22, 26, 30};
  localparam int VEC_WID [NVEC] = '{1, 3, 0, 5, 16, 2, 20, 1};

  logic refClk = 1'b0, fastClk = 1'b0, rstN = 1'b0, discIn = 1'b0, readAck = 1'b0;
  logic [STAMP_W-1:0] coarseTime = 10'd1000;
  logic dataValid;
  logic [WORD_W-1:0] dataWord;

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  pix_hit_capture #(.STAMP_W(STAMP_W), .TOT_W(TOT_W), .FINE_W(FINE_W)) uut (
    .refClk(refClk), .fastClk(fastClk), .rstN(rstN), .discIn(discIn),
    .coarseTime(coarseTime), .readAck(readAck),
    .dataValid(dataValid), .dataWord(dataWord)
  );

  initial forever #(REF_PERIOD/2) refClk = ~refClk;
  initial forever #(FAST_HALF) fastClk = ~fastClk;
  initial forever begin
    @(posedge refClk);
    #1 coarseTime = coarseTime + 1'b1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // fires one pulse; returns expected word
  task automatic firePulse(input int off, input int wid, output logic [WORD_W-1:0] expWord);
    logic [STAMP_W-1:0] st;
    int tot, fine;
    @(posedge refClk);
    #(off);
    discIn = 1'b1;
    st = coarseTime;
    if (wid == 0) begin
      #8 discIn = 1'b0;
    end else begin
      repeat (wid) @(posedge refClk);
      #(off);
      discIn = 1'b0;
    end
    tot  = (wid == 0) ? 1 : ((wid > 15) ? 15 : wid);
    fine = (REF_PERIOD - off) / (2 * FAST_HALF);
    expWord = {st, TOT_W'(tot), FINE_W'(fine)};
  endtask

  task automatic waitValid(output int cyc);
    cyc = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge refClk);
      if (dataValid) begin
        cyc = i;
        break;
      end
    end
  endtask

  task automatic ackWord();
    @(negedge refClk);
    readAck = 1'b1;
    @(negedge refClk);
    readAck = 1'b0;
    check(dataValid == 1'b0, "R8 valid after ack", dataValid, 0);
    @(negedge refClk);
    check(dataValid == 1'b0, "R8 valid one cycle later", dataValid, 0);
  endtask

  initial begin
    #(REF_PERIOD * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [WORD_W-1:0] expW, expA;
    int cyc;
    repeat (4) @(negedge refClk);
    rstN = 1'b1;
    @(negedge refClk);
    check(dataValid == 1'b0, "R1 reset valid", dataValid, 0);
    check(dataWord == '0, "R1 reset word", dataWord, 0);
    repeat (4) @(negedge refClk);

    // table walk: phase sweep (R4), widths incl. short and saturating (R5, R6), stamp wrap (R3)
    for (int v = 0; v < NVEC; v++) begin
      firePulse(VEC_OFF[v], VEC_WID[v], expW);
      waitValid(cyc);
      check(cyc != 0 && cyc <= 6, "R2 valid latency", cyc, 6);
      check(dataWord[17:8] == expW[17:8], "R3 coarse stamp", dataWord[17:8], expW[17:8]);
      check(dataWord[3:0] == expW[3:0], "R4 fine count", dataWord[3:0], expW[3:0]);
      if (VEC_WID[v] == 0)
        check(dataWord[7:4] == expW[7:4], "R6 short pulse ToT", dataWord[7:4], expW[7:4]);
      else
        check(dataWord[7:4] == expW[7:4], "R5 ToT count", dataWord[7:4], expW[7:4]);
      repeat (3) @(negedge refClk);
      check(dataValid && dataWord == expW, "R7 held until ack", dataWord, expW);
      ackWord();
      repeat (3) @(negedge refClk);
    end

    // pending word: a second pulse must be ignored
    firePulse(10, 2, expA);
    waitValid(cyc);
    check(dataWord == expA, "R9 first word", dataWord, expA);
    firePulse(4, 3, expW);
    repeat (8) @(negedge refClk);
    check(dataValid && dataWord == expA, "R9 word unchanged by pending hit", dataWord, expA);
    ackWord();
    cyc = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge refClk);
      if (dataValid) cyc++;
    end
    check(cyc == 0, "R9 no word from ignored hit", cyc, 0);

    // fresh hit after the ignored one reports its own ToT
    firePulse(8, 4, expW);
    waitValid(cyc);
    check(dataWord == expW, "R5 fresh hit after ignored", dataWord, expW);
    ackWord();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule